// File: doc/BRIEF.md
# Context-Tagged Translation Cache Tag Store

This block is the tag side of a cache of translated micro-op blocks. Each cached block covers a run of decoded instructions (at most 64 micro-ops) that ends at a branch of any kind or at a barrier such as a microcode assist. The micro-op payload lives elsewhere. This block only maps an entry key to the slot index where that payload sits. The store is fully associative, so every entry is compared against the key in parallel.

The 128-bit key has these fields, from the top bit down:

| Bits | Field |
|---|---|
| [127:80] | 48-bit virtual entry address |
| [79:42] | 38-bit frame number of the first page |
| [41:4] | 38-bit frame number of a second page |
| [3] | flag: the block crosses into the second page |
| [2] | 64-bit mode |
| [1] | kernel mode |
| [0] | direction flag |

A block fetched from the same address and the same pages under different context bits is therefore a separate entry.

There are three ports:
- **Lookup** answers within the same cycle.
- **Insert** writes a key into a slot. The slot is the one already holding that key if there is one, otherwise the lowest free slot, otherwise the slot named by the victim input.
- **Invalidate-by-frame** drops, in one cycle, every entry whose pages include the given frame. It reports the number dropped one cycle later.

Insert is a valid/ready stream. `ins_ready` is low in any cycle with an invalidate, and the insert then waits. A write takes effect at the clock edge where `ins_valid` and `ins_ready` are both high. Lookup and invalidate are plain control pins.

Top module: `tct_tag_store`

## Requirements
- R1: After reset no entry is valid: every lookup misses, `inv_done` is 0 and `ins_ready` is 1.
- R2: After an accepted insert, a lookup with the identical key hits and returns that slot, starting in the next cycle.
- R3: Keys that differ only in a context bit (key bits [2:0]) are separate entries: a lookup with one does not hit the other.
- R4: An insert of a key not present goes to the lowest-numbered free slot, shown on `ins_slot` in the same cycle.
- R5: When all slots are valid and the key is not present, the insert overwrites the slot given by `ins_victim`, and the old key in that slot then misses.
- R6: An insert of a key already present rewrites that same slot, so no key is ever stored twice.
- R7: An invalidate clears every valid entry whose first-page frame (bits [79:42]) equals `inv_frame`. It also clears every entry whose crossing flag (bit [3]) is set and whose second-page frame (bits [41:4]) equals `inv_frame`. When the crossing flag is clear, the second-page frame is ignored.
- R8: One cycle after an invalidate, `inv_done` pulses high for exactly one cycle, and `inv_count` then gives the number of entries cleared.
- R9: A lookup in the same cycle as an invalidate misses on any entry that the invalidate clears (invalidate wins).
- R10: `ins_ready` is 0 in any cycle with `inv_valid` high, and an insert offered in that cycle is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | 128 | Lookup key |
| lk_hit | output | 1 | Lookup hit (same cycle) |
| lk_slot | output | 3 | Slot of the hit, 0 on a miss |
| ins_valid | input | 1 | Insert offered |
| ins_ready | output | 1 | Insert accepted this cycle |
| ins_key | input | 128 | Key to insert |
| ins_victim | input | 3 | Slot to replace when the store is full |
| ins_slot | output | 3 | Slot the insert writes |
| inv_valid | input | 1 | Invalidate-by-frame command |
| inv_frame | input | 38 | Frame number to drop |
| inv_done | output | 1 | Invalidate completed (one-cycle pulse) |
| inv_count | output | 4 | Entries cleared by the last invalidate |

## Verification
The assertions check the following on every cycle:
- at most one entry matches any lookup key;
- a reported hit names a valid entry that the invalidate in that cycle is not clearing;
- `ins_ready` is low during an invalidate;
- every entry selected by an invalidate is invalid afterwards;
- `inv_done` only follows an invalidate.

The bench scenarios cover the rest:
- the choice of slot (lowest free slot, reuse of a present key, victim when full);
- the separation of keys by context bit;
- the ignored second-page frame when the crossing flag is clear;
- the exact count reported after an invalidate.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int VA_W  = 48;
  localparam int FN_W  = 38;
  localparam int CTX_W = 3;
  localparam int KEY_W = VA_W + 2 * FN_W + 1 + CTX_W;

  typedef struct packed {
    logic [VA_W-1:0]  va;
    logic [FN_W-1:0]  lo_fn;
    logic [FN_W-1:0]  hi_fn;
    logic             spans;
    logic [CTX_W-1:0] ctx;   // [2] 64-bit mode, [1] kernel, [0] direction
  } tc_key_t;
endpackage

// File: rtl/tct_entry.sv
module tct_entry
  import tct_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  tc_key_t         wr_key,
  input  logic            clr,
  input  tc_key_t         lk_key,
  input  tc_key_t         dup_key,
  input  logic [FN_W-1:0] inv_frame,
  output logic            valid,
  output logic            lk_match,
  output logic            dup_match,
  output logic            inv_match
);
  tc_key_t key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      key_q <= '0;
    end else if (clr) begin
      valid <= 1'b0;
    end else if (wr_en) begin
      valid <= 1'b1;
      key_q <= wr_key;
    end
  end

  always_comb begin
    lk_match  = valid && (key_q == lk_key);
    dup_match = valid && (key_q == dup_key);
    inv_match = valid && ((key_q.lo_fn == inv_frame) ||
                          (key_q.spans && (key_q.hi_fn == inv_frame)));
  end
endmodule

// File: rtl/tct_first.sv
module tct_first #(
  parameter int N   = 8,
  parameter int IDX = 3
) (
  input  logic [N-1:0]   vec,
  output logic           found,
  output logic [IDX-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX'(i);
      end
    end
  end
endmodule

// File: rtl/tct_tag_store.sv
module tct_tag_store
  import tct_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int SLOT_W = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [KEY_W-1:0]  lk_key,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_slot,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [KEY_W-1:0]  ins_key,
  input  logic [SLOT_W-1:0] ins_victim,
  output logic [SLOT_W-1:0] ins_slot,
  input  logic              inv_valid,
  input  logic [FN_W-1:0]   inv_frame,
  output logic              inv_done,
  output logic [CNT_W-1:0]  inv_count
);
  logic [ENTRIES-1:0] valid_q, lk_match, dup_match, inv_match, inv_hit, wr_sel;
  logic               lk_found, dup_found, free_found;
  logic [SLOT_W-1:0]  lk_idx, dup_idx, free_idx;

  assign inv_hit   = inv_match & {ENTRIES{inv_valid}};
  assign ins_ready = !inv_valid;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign wr_sel[g] = ins_valid && ins_ready && (ins_slot == SLOT_W'(g));
    tct_entry u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_sel[g]), .wr_key(tc_key_t'(ins_key)),
      .clr(inv_hit[g]),
      .lk_key(tc_key_t'(lk_key)), .dup_key(tc_key_t'(ins_key)),
      .inv_frame(inv_frame),
      .valid(valid_q[g]), .lk_match(lk_match[g]),
      .dup_match(dup_match[g]), .inv_match(inv_match[g])
    );
  end

  tct_first #(.N(ENTRIES), .IDX(SLOT_W)) u_lk_pick (
    .vec(lk_match & ~inv_hit), .found(lk_found), .idx(lk_idx));
  tct_first #(.N(ENTRIES), .IDX(SLOT_W)) u_dup_pick (
    .vec(dup_match), .found(dup_found), .idx(dup_idx));
  tct_first #(.N(ENTRIES), .IDX(SLOT_W)) u_free_pick (
    .vec(~valid_q), .found(free_found), .idx(free_idx));

  always_comb begin
    lk_hit  = lk_valid && lk_found;
    lk_slot = lk_hit ? lk_idx : '0;
    if (dup_found)       ins_slot = dup_idx;
    else if (free_found) ins_slot = free_idx;
    else                 ins_slot = ins_victim;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inv_done  <= 1'b0;
      inv_count <= '0;
    end else begin
      inv_done <= inv_valid;
      if (inv_valid) inv_count <= CNT_W'($countones(inv_hit));
    end
  end
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
  parameter int ENTRIES = 8,
  parameter int SLOT_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] inv_hit,
  input logic               lk_hit,
  input logic [SLOT_W-1:0]  lk_slot,
  input logic               inv_valid,
  input logic               ins_ready,
  input logic               inv_done
);
  AST_ONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match)); // R6
  AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid_q[lk_slot]); // R2
  AST_INV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !inv_hit[lk_slot]); // R9
  AST_INS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !ins_ready); // R10
  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> ((valid_q & $past(inv_hit)) == '0)); // R7
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_done |-> $past(inv_valid)); // R8
endmodule

bind tct_tag_store tct_checker #(.ENTRIES(ENTRIES), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_q(valid_q), .lk_match(lk_match),
  .inv_hit(inv_hit), .lk_hit(lk_hit), .lk_slot(lk_slot),
  .inv_valid(inv_valid), .ins_ready(ins_ready), .inv_done(inv_done)
);

// File: tb/tct_tag_store_bench.sv
`timescale 1ns/1ps
module tct_tag_store_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lk_valid = 1'b0, ins_valid = 1'b0, inv_valid = 1'b0;
  logic [127:0] lk_key = '0, ins_key = '0;
  logic [2:0]   ins_victim = '0;
  logic [37:0]  inv_frame = '0;
  logic         lk_hit, ins_ready, inv_done;
  logic [2:0]   lk_slot, ins_slot;
  logic [3:0]   inv_count;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tct_tag_store u_tct_tag_store (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_key(lk_key),
    .lk_hit(lk_hit), .lk_slot(lk_slot), .ins_valid(ins_valid),
    .ins_ready(ins_ready), .ins_key(ins_key), .ins_victim(ins_victim),
    .ins_slot(ins_slot), .inv_valid(inv_valid), .inv_frame(inv_frame),
    .inv_done(inv_done), .inv_count(inv_count));

  function automatic logic [127:0] mk(input logic [47:0] va, input logic [37:0] lo,
                                      input logic [37:0] hi, input logic sp,
                                      input logic [2:0] ctx);
    return {va, lo, hi, sp, ctx};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic look(input logic [127:0] k, input int hit, input int slot, input string req);
    lk_key = k; lk_valid = 1'b1; #1;
    check({req, " hit"}, int'(lk_hit), hit);
    if (hit != 0) check({req, " slot"}, int'(lk_slot), slot);
    @(negedge clk); lk_valid = 1'b0;
  endtask

  task automatic put(input logic [127:0] k, input logic [2:0] vic, input int slot, input string req);
    ins_key = k; ins_victim = vic; ins_valid = 1'b1; #1;
    check({req, " ins_slot"}, int'(ins_slot), slot);
    @(negedge clk); ins_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(); #1;
    check("R1 ins_ready", int'(ins_ready), 1);
    check("R1 inv_done", int'(inv_done), 0);
    @(negedge clk);
    look(mk(48'h1000, 38'h10, 38'h0, 1'b0, 3'b100), 0, 0, "R1 empty lookup");
  endtask

  task automatic t_basic();
    logic [127:0] a = mk(48'h4000, 38'h40, 38'h41, 1'b1, 3'b100);
    logic [127:0] b = mk(48'h4000, 38'h40, 38'h41, 1'b1, 3'b101);
    do_reset();
    put(a, 3'd0, 0, "R4 first free");
    look(a, 1, 0, "R2 hit after insert");
    look(b, 0, 0, "R3 dir flag differs");
    look(mk(48'h4000, 38'h40, 38'h41, 1'b1, 3'b110), 0, 0, "R3 kernel differs");
    put(b, 3'd0, 1, "R4 next free");
    look(b, 1, 1, "R3 separate entry");
    put(a, 3'd6, 0, "R6 rewrite same slot");
    put(mk(48'h5000, 38'h50, 38'h0, 1'b0, 3'b100), 3'd6, 2, "R6 no duplicate used");
  endtask

  task automatic t_victim();
    do_reset();
    for (int i = 0; i < 8; i++)
      put(mk(48'h8000 + 48'(i), 38'h80 + 38'(i), 38'h0, 1'b0, 3'b100), 3'd0, i, "R4 fill");
    put(mk(48'h9999, 38'h99, 38'h0, 1'b0, 3'b000), 3'd5, 5, "R5 victim slot");
    look(mk(48'h9999, 38'h99, 38'h0, 1'b0, 3'b000), 1, 5, "R5 new key hits");
    look(mk(48'h8005, 38'h85, 38'h0, 1'b0, 3'b100), 0, 0, "R5 old key gone");
    look(mk(48'h8004, 38'h84, 38'h0, 1'b0, 3'b100), 1, 4, "R5 neighbour kept");
  endtask

  task automatic t_invalidate();
    logic [127:0] k0 = mk(48'hA000, 38'h10, 38'h11, 1'b1, 3'b100);
    logic [127:0] k1 = mk(48'hB000, 38'h20, 38'h11, 1'b0, 3'b100);
    logic [127:0] k2 = mk(48'hC000, 38'h11, 38'h0,  1'b0, 3'b010);
    logic [127:0] k3 = mk(48'hD000, 38'h30, 38'h31, 1'b1, 3'b001);
    logic [127:0] kb = mk(48'hE000, 38'h60, 38'h0,  1'b0, 3'b100);
    do_reset();
    put(k0, 3'd0, 0, "R4 inv setup");
    put(k1, 3'd0, 1, "R4 inv setup");
    put(k2, 3'd0, 2, "R4 inv setup");
    put(k3, 3'd0, 3, "R4 inv setup");
    inv_frame = 38'h11; inv_valid = 1'b1;
    lk_key = k0; lk_valid = 1'b1;
    ins_key = kb; ins_valid = 1'b1; #1;
    check("R9 lookup loses to invalidate", int'(lk_hit), 0);
    check("R10 ins_ready low", int'(ins_ready), 0);
    @(negedge clk);
    inv_valid = 1'b0; lk_valid = 1'b0; ins_valid = 1'b0;
    check("R8 inv_done pulse", int'(inv_done), 1);
    check("R8 inv_count", int'(inv_count), 2);
    look(k0, 0, 0, "R7 high frame match cleared");
    check("R8 inv_done one cycle", int'(inv_done), 0);
    look(k2, 0, 0, "R7 low frame match cleared");
    look(k1, 1, 1, "R7 high frame ignored without crossing");
    look(k3, 1, 3, "R7 unrelated kept");
    look(kb, 0, 0, "R10 blocked insert not written");
    put(kb, 3'd7, 0, "R4 freed slot reused");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_victim();
    t_invalidate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule